// File: doc/BRIEF.md
# Synchronous Serial Port Master with Dual FIFOs

This block is a full-duplex serial port that drives the serial clock itself. It takes 32-bit words from a host through a transmit FIFO and shifts out only the low bits of each word. The word length is programmable from 4 to 32 bits, and bits leave most significant first. On every generated clock period it also samples one bit from the attached device. It assembles those bits into a word of the same length and places the word, right-justified, in a separate receive FIFO.

Two frame formats share one engine. In select format an active-low select is held for the whole word, with a one-period gap between words. In pulse format a one-period frame strobe comes just before the first data bit of each word. The serial clock comes from a programmable divider of the system clock. The host reads received words through a fall-through read port. It watches full and empty flags on both FIFOs, plus sticky flags for a dropped host write and a lost received word.

Top module: `ssp_top`

## Requirements
- R1: While a word is active, each serial clock period both presents one transmit bit on `mosi` and samples one bit of `miso` on the rising edge of `sclk`.
- R2: The word length is `cfg_wlen_m1`+1 bits. Codes 0, 1 and 2 are treated as 3, so the shortest word is 4 bits.
- R3: The transmit and receive FIFOs are independent and each holds 16 entries of 32 bits. `tx_full` asserts after 16 unsent writes, and `rx_full` asserts after 16 unread received words.
- R4: For each host word, bits `wlen-1` down to 0 are sent in that order, and bits above the word length are never sent.
- R5: In select format (`cfg_fmt`=0), `ssel_n` goes low half a serial period before the first rising edge of `sclk`. It stays low through exactly `wlen` rising edges, rises with the last falling edge, and `tframe` stays low.
- R6: In pulse format (`cfg_fmt`=1), `tframe` is high for exactly one serial period, and that period ends where the first data bit begins. `ssel_n` stays high throughout.
- R7: The serial period is 2×`cfg_half` system clocks (`cfg_half`=0 acts as 1), low half first. `mosi` changes only while `sclk` is low.
- R8: A received word enters the receive FIFO right-justified, with the first received bit at position `wlen-1`, and is zero-extended to 32 bits.
- R9: A host write while `tx_full` is high is discarded and sets the sticky `tx_ovf` flag. The discarded word is never transmitted.
- R10: A word received while `rx_full` is high is discarded and sets the sticky `rx_ovr` flag. The FIFO contents already held are kept unchanged.
- R11: After reset, and whenever `enable` is low or the transmit FIFO is empty between words, `sclk` is low, `ssel_n` is high and `tframe` is low. Both FIFOs come out of reset empty and both flags come out of reset clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new words to start |
| cfg_fmt | input | 1 | Frame format: 0 select, 1 pulse |
| cfg_wlen_m1 | input | 5 | Word length minus one |
| cfg_half | input | 8 | Half serial period in system clocks |
| wr_en | input | 1 | Host write strobe into transmit FIFO |
| wr_data | input | 32 | Host write word |
| rd_en | input | 1 | Host pop strobe from receive FIFO |
| rd_data | output | 32 | Head of receive FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_avail | output | 1 | Receive FIFO not empty |
| tx_ovf | output | 1 | Sticky: host write dropped |
| rx_ovr | output | 1 | Sticky: received word dropped |
| sclk | output | 1 | Serial clock |
| ssel_n | output | 1 | Active-low select (select format) |
| tframe | output | 1 | Frame strobe (pulse format) |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A bit counter that is off by one shows up within the first word. The device model then sees the wrong number of rising edges, and the received word comes back shifted. A stuck FIFO pointer shows within 16 writes, through wrong full or empty flags or a repeated word. A wrong state or divider count changes the frame strobe width or the clock high time, and that is visible on the next word.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FRAME,
      ST_DATA,
      ST_GAP
   } ssp_state_t;

   typedef enum logic {
      FMT_SEL   = 1'b0,
      FMT_PULSE = 1'b1
   } ssp_fmt_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   logic [AW:0]  wptr, rptr;
   logic [W-1:0] mem [DEPTH];
   logic         do_wr, do_rd;

   assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign empty = (wptr == rptr);
   assign do_wr = push && !full;
   assign do_rd = pop && !empty;
   assign rdata = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (do_wr && wptr[AW-1:0] == AW'(e)) mem[e] <= wdata;
      end
   end
endmodule

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] hcnt;
   logic [DIV_W-1:0] hmax;

   assign hmax = (half == '0) ? '0 : half - 1'b1;
   assign tick = run && (hcnt == hmax);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || tick) hcnt <= '0;
      else                         hcnt <= hcnt + 1'b1;
   end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
   import ssp_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int MIN_LEN = 4,
   parameter int LEN_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fmt,
   input  logic [LEN_W-1:0]  wlen_code,
   input  logic              tick,
   input  logic              tx_empty,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              miso,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_word,
   output logic              run,
   output logic              sclk,
   output logic              ssel_n,
   output logic              tframe,
   output logic              mosi
);
   localparam logic [LEN_W-1:0] MIN_CODE = LEN_W'(MIN_LEN - 1);

   ssp_state_t        st;
   ssp_fmt_t          fmt_q;
   logic              ph;
   logic [LEN_W-1:0]  bcnt;
   logic [LEN_W-1:0]  code_eff;
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_sr;

   assign code_eff = (wlen_code < MIN_CODE) ? MIN_CODE : wlen_code;
   assign tx_pop   = (st == ST_IDLE) && enable && !tx_empty;
   assign run      = (st != ST_IDLE);
   assign rx_push  = tick && ph && (st == ST_DATA) && (bcnt == '0);
   assign rx_word  = rx_sr;

   assign sclk   = ph;
   assign ssel_n = !((st == ST_DATA) && (fmt_q == FMT_SEL));
   assign tframe = (st == ST_FRAME);
   assign mosi   = (st == ST_DATA) ? tx_q[bcnt] : 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         fmt_q <= FMT_SEL;
         ph    <= 1'b0;
         bcnt  <= '0;
         tx_q  <= '0;
         rx_sr <= '0;
      end else if (st == ST_IDLE) begin
         if (tx_pop) begin
            fmt_q <= ssp_fmt_t'(fmt);
            tx_q  <= tx_data;
            rx_sr <= '0;
            bcnt  <= code_eff;
            ph    <= 1'b0;
            st    <= (ssp_fmt_t'(fmt) == FMT_PULSE) ? ST_FRAME : ST_DATA;
         end
      end else if (tick) begin
         if (!ph) begin
            ph <= 1'b1;
            if (st == ST_DATA) rx_sr <= {rx_sr[DATA_W-2:0], miso};
         end else begin
            ph <= 1'b0;
            case (st)
               ST_FRAME: st <= ST_DATA;
               ST_DATA: begin
                  if (bcnt == '0) st <= (fmt_q == FMT_PULSE) ? ST_IDLE : ST_GAP;
                  else            bcnt <= bcnt - 1'b1;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ssp_top.sv
module ssp_top #(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 16,
   parameter int DIV_W      = 8,
   parameter int MIN_LEN    = 4,
   parameter int LEN_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              cfg_fmt,
   input  logic [LEN_W-1:0]  cfg_wlen_m1,
   input  logic [DIV_W-1:0]  cfg_half,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              tx_full,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              rx_avail,
   output logic              tx_ovf,
   output logic              rx_ovr,
   output logic              sclk,
   output logic              ssel_n,
   output logic              tframe,
   output logic              mosi,
   input  logic              miso
);
   if (DATA_W < MIN_LEN || (1 << LEN_W) != DATA_W) begin : g_bad_width
      $error("ssp_top: DATA_W must be a power of two not below MIN_LEN");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ssp_top: FIFO_DEPTH must be a power of two of at least 2");
   end
   if (MIN_LEN < 2) begin : g_bad_min
      $error("ssp_top: MIN_LEN must be at least 2");
   end

   logic              tick, run;
   logic              tx_pop, rx_push, rx_empty;
   logic [DATA_W-1:0] tx_head, rx_word;

   ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(wr_en), .wdata(wr_data),
      .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
   );

   ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
      .pop(rd_en), .rdata(rd_data), .full(rx_full), .empty(rx_empty)
   );

   ssp_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .half(cfg_half), .tick(tick)
   );

   ssp_engine #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fmt(cfg_fmt),
      .wlen_code(cfg_wlen_m1), .tick(tick), .tx_empty(tx_empty),
      .tx_data(tx_head), .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push),
      .rx_word(rx_word), .run(run), .sclk(sclk), .ssel_n(ssel_n),
      .tframe(tframe), .mosi(mosi)
   );

   assign rx_avail = !rx_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_ovf <= 1'b0;
         rx_ovr <= 1'b0;
      end else begin
         if (wr_en && tx_full)   tx_ovf <= 1'b1;
         if (rx_push && rx_full) rx_ovr <= 1'b1;
      end
   end
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic tx_full,
   input logic rx_full,
   input logic rx_avail,
   input logic tx_ovf,
   input logic rx_ovr,
   input logic sclk,
   input logic ssel_n,
   input logic tframe,
   input logic mosi
);
   // R9
   tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tx_full) |=> tx_ovf);

   // R9
   tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ovf |=> tx_ovf);

   // R10
   rx_ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr |=> rx_ovr);

   // R6
   frame_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tframe |-> ssel_n);

   // R7
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   // R5
   sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ssel_n) |-> !sclk);

   // R3
   rx_full_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> rx_avail);
endmodule

bind ssp_top ssp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_full(tx_full),
   .rx_full(rx_full), .rx_avail(rx_avail), .tx_ovf(tx_ovf), .rx_ovr(rx_ovr),
   .sclk(sclk), .ssel_n(ssel_n), .tframe(tframe), .mosi(mosi)
);

// File: tb/sim_ssp_top.sv
module sim_ssp_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        cfg_fmt = 1'b0;
   logic [4:0]  cfg_wlen_m1 = 5'd7;
   logic [7:0]  cfg_half = 8'd1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        tx_full, tx_empty, rx_full, rx_avail, tx_ovf, rx_ovr;
   logic        sclk, ssel_n, tframe, mosi;
   logic        miso = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   ssp_top u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_fmt(cfg_fmt),
      .cfg_wlen_m1(cfg_wlen_m1), .cfg_half(cfg_half), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tx_full(tx_full),
      .tx_empty(tx_empty), .rx_full(rx_full), .rx_avail(rx_avail),
      .tx_ovf(tx_ovf), .rx_ovr(rx_ovr), .sclk(sclk), .ssel_n(ssel_n),
      .tframe(tframe), .mosi(mosi), .miso(miso)
   );

   function automatic logic [31:0] slv_pat(input int i);
      return 32'h3C5A_96E1 ^ (32'(i) * 32'h0101_0107);
   endfunction

   function automatic logic [31:0] lo_mask(input int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
   endfunction

   // device model: records mosi on rising sclk, drives miso after falling sclk
   int          bwl = 8;
   int          xfer_idx = 0;
   int          cap_bits = 0;
   logic [31:0] cap_word = '0;
   logic [31:0] slv_word = '0;
   logic        p_sclk = 1'b0;
   logic        p_sel = 1'b1;
   int          sel_in_pulse = 0;
   int          frame_in_sel = 0;

   always @(sclk, ssel_n, tframe) begin
      if (cfg_fmt && ssel_n === 1'b0) sel_in_pulse++;
      if (!cfg_fmt && tframe === 1'b1) frame_in_sel++;
      if (!cfg_fmt && p_sel === 1'b1 && ssel_n === 1'b0) begin
         cap_bits = 0;
         cap_word = '0;
         slv_word = slv_pat(xfer_idx);
         xfer_idx++;
         miso = slv_word[bwl-1];
      end
      if (p_sclk === 1'b0 && sclk === 1'b1) begin
         if (cfg_fmt && tframe === 1'b1) begin
            cap_bits = 0;
            cap_word = '0;
            slv_word = slv_pat(xfer_idx);
            xfer_idx++;
         end else if ((cfg_fmt && tframe === 1'b0) || (!cfg_fmt && ssel_n === 1'b0)) begin
            cap_word = {cap_word[30:0], mosi};
            cap_bits++;
         end
      end
      if (p_sclk === 1'b1 && sclk === 1'b0)
         miso = (cap_bits < bwl) ? slv_word[bwl-1-cap_bits] : 1'b0;
      p_sclk = sclk;
      p_sel  = ssel_n;
   end

   // period measurements in system clocks
   int hi_cnt = 0, hi_last = 0, tf_cnt = 0, tf_last = 0;
   always @(posedge clk) begin
      if (sclk) hi_cnt++;
      else if (hi_cnt != 0) begin hi_last = hi_cnt; hi_cnt = 0; end
      if (tframe) tf_cnt++;
      else if (tf_cnt != 0) begin tf_last = tf_cnt; tf_cnt = 0; end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push_word(input logic [31:0] w);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pop_word(output logic [31:0] w);
      @(negedge clk);
      w = rd_data;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_cond_avail(input int limit);
      for (int i = 0; i < limit && !rx_avail; i++) @(negedge clk);
   endtask

   task automatic one_word(input bit fmt, input int wl, input int code);
      logic [31:0] txw, got;
      int idx;
      cfg_fmt = fmt;
      cfg_wlen_m1 = 5'(code);
      bwl = wl;
      txw = 32'hA5C3_96F1 ^ (32'(wl) * 32'h0101_0101) ^ {31'd0, fmt};
      idx = xfer_idx;
      push_word(txw);
      wait_cond_avail(4000);
      repeat (4 * int'(cfg_half) + 6) @(negedge clk);
      check($sformatf("R2 bit count fmt=%0d wl=%0d", fmt, wl), 32'(cap_bits), 32'(wl));
      check($sformatf("R4 tx bits fmt=%0d wl=%0d", fmt, wl), cap_word, txw & lo_mask(wl));
      pop_word(got);
      check($sformatf("R8 rx word fmt=%0d wl=%0d", fmt, wl), got, slv_pat(idx) & lo_mask(wl));
   endtask

   initial begin
      logic [31:0] got;
      int base;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 sclk", {31'd0, sclk}, 32'd0);
      check("R11 ssel_n", {31'd0, ssel_n}, 32'd1);
      check("R11 tframe", {31'd0, tframe}, 32'd0);
      check("R11 flags", {28'd0, tx_empty, rx_avail, tx_ovf, rx_ovr}, 32'h8);
      rst_n = 1'b1;
      enable = 1'b1;
      @(negedge clk);

      // R1 R2 R4 R8: sweep every length in both formats
      for (int f = 0; f < 2; f++)
         for (int wl = 4; wl <= 32; wl++) one_word(f[0], wl, wl - 1);

      // R2 short codes clamp to 4 bits
      for (int c = 0; c < 3; c++) one_word(1'b0, 4, c);
      one_word(1'b1, 4, 1);

      // R5 R6 format exclusivity over the whole sweep
      check("R5 no frame strobe in select format", 32'(frame_in_sel), 32'd0);
      check("R6 no select in pulse format", 32'(sel_in_pulse), 32'd0);

      // R7 R6 divider timing with half period 3
      cfg_half = 8'd3;
      one_word(1'b1, 12, 11);
      check("R7 sclk high time", 32'(hi_last), 32'd3);
      check("R6 frame strobe width", 32'(tf_last), 32'd6);
      cfg_half = 8'd0;
      one_word(1'b0, 9, 8);
      check("R7 half code 0 high time", 32'(hi_last), 32'd1);
      cfg_half = 8'd1;

      // R3 R9 transmit FIFO depth and overflow
      enable = 1'b0;
      cfg_fmt = 1'b0;
      cfg_wlen_m1 = 5'd7;
      bwl = 8;
      for (int k = 0; k < 16; k++) push_word(32'h100 + 32'(k));
      check("R3 tx_full after 16", {31'd0, tx_full}, 32'd1);
      check("R9 no overflow yet", {31'd0, tx_ovf}, 32'd0);
      push_word(32'h0000_00EE);
      check("R9 overflow set", {31'd0, tx_ovf}, 32'd1);
      repeat (20) @(negedge clk);
      // R11 disabled with data pending: no activity
      check("R11 held while disabled", {29'd0, sclk, ssel_n, tx_empty}, 32'h2);
      base = xfer_idx;
      enable = 1'b1;
      for (int i = 0; i < 4000 && !tx_empty; i++) @(negedge clk);
      repeat (30) @(negedge clk);
      check("R9 dropped word not sent", 32'(xfer_idx - base), 32'd16);
      check("R9 last word sent", cap_word, 32'h0F);
      check("R3 rx_full after 16", {31'd0, rx_full}, 32'd1);
      check("R10 no overrun yet", {31'd0, rx_ovr}, 32'd0);

      // R10 receive overrun keeps stored words
      push_word(32'h55);
      repeat (40) @(negedge clk);
      check("R10 overrun set", {31'd0, rx_ovr}, 32'd1);
      check("R9 overflow still set", {31'd0, tx_ovf}, 32'd1);
      for (int k = 0; k < 16; k++) begin
         pop_word(got);
         check($sformatf("R10 stored word %0d", k), got, slv_pat(base + k) & 32'hFF);
      end
      check("R3 rx empty after 16 reads", {31'd0, rx_avail}, 32'd0);
      check("R11 idle lines", {30'd0, sclk, ssel_n}, 32'h1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 190000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule